// File: doc/BRIEF.md
# GPIO Bank Configuration Write Lock

This block sits beside the register file of a 32-bit GPIO bank and decides, on every bus write, whether the addressed register may be updated. It decodes the word address of each write into one permit line per register slot. While the bank is locked, every permit line is held low, so data, direction and other configuration registers keep their old contents.

Two slots are reserved as lock registers: word offset 0x00 (the "primary lock") and word offset 0x7C (the "secondary lock"). A write of any value to either one engages the lock. The only way out is an ordered key pair. First the secondary lock is written with 0xC0DE1248. The very next bus write must then put 0xC0DEFA73 into the primary lock. The lock state is offered as a read word. Reads of all other registers bypass the block.

Top module: `gpio_wlock_unit`

## Requirements
- R1: After reset the bank is unlocked, `lock_rdata_o` reads 0 and no permit line is high.
- R2: `lock_rdata_o` reads 1 when locked and 0 when unlocked, with bits 31..1 always 0. It reflects a lock change in the cycle after the write edge.
- R3: A valid write of any value to offset 0x00 or to offset 0x7C locks the bank from the next cycle on. The single exception is the completing key write of R4.
- R4: A write of 0xC0DE1248 to offset 0x7C, followed by a next valid write of 0xC0DEFA73 to offset 0x00, unlocks the bank. Idle cycles in between do not break the pair.
- R5: While locked, all permit lines are 0. A write to the data-out register (offset 0x0C, permit bit 3) is therefore dropped and its old value kept.
- R6: While unlocked, a valid write to offset 4*k (bits [6:2] of the address give k) raises only `wr_permit_o[k]`, in the same cycle as the write.
- R7: Any valid write other than the first key to offset 0x7C discards a pending first key. This covers a write to another offset, a wrong value, or the second key without the first. The bank stays locked in all these cases.
- R8: The two lock slots (permit bits 0 and 31) never receive a permit, locked or not.
- R9: A cycle with `wr_valid_i` low raises no permit and changes neither the lock nor a pending first key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write strobe for this cycle |
| wr_addr_i | input | 7 | Byte address of the write within the bank |
| wr_data_i | input | 32 | Write data |
| wr_permit_o | output | 32 | Per-slot write enable for the protected registers |
| lock_rdata_o | output | 32 | Lock status read word |
| locked_o | output | 1 | Lock status |

## Verification
The permit lines are combinational from the write strobe and the registered lock, so they are due in the same cycle as the write. The bench samples them 2 ns after driving the inputs, before the rising edge. The lock status and the bench's shadow data-out register change one edge after the write, so they are sampled 1 ns after that edge. Every expected item in the scoreboard carries both sample points for one bus cycle, so a one-cycle slip in either result shows up as a mismatch.

// File: rtl/gpio_wlock_pkg.sv
package gpio_wlock_pkg;
  localparam int unsigned KEY_W       = 32;
  localparam logic [KEY_W-1:0] KEY_FIRST  = 32'hC0DE_1248;
  localparam logic [KEY_W-1:0] KEY_SECOND = 32'hC0DE_FA73;
  localparam int unsigned LOCK_LO_OFS = 'h00;
  localparam int unsigned LOCK_HI_OFS = 'h7C;
  localparam int unsigned LOCK_LO_SLOT = LOCK_LO_OFS / 4;
  localparam int unsigned LOCK_HI_SLOT = LOCK_HI_OFS / 4;
endpackage

// File: rtl/gpio_wlock_decode.sv
module gpio_wlock_decode #(
  parameter int unsigned ADDR_W = 7,
  localparam int unsigned NSLOT = 1 << (ADDR_W - 2)
) (
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic [NSLOT-1:0]  sel_o,
  output logic              hit_lo_o,
  output logic              hit_hi_o
);
  import gpio_wlock_pkg::*;

  logic [ADDR_W-3:0] slot;
  assign slot = wr_addr_i[ADDR_W-1:2];

  for (genvar k = 0; k < NSLOT; k++) begin : g_sel
    assign sel_o[k] = wr_valid_i && (slot == (ADDR_W-2)'(k));
  end

  assign hit_lo_o = sel_o[LOCK_LO_SLOT];
  assign hit_hi_o = sel_o[LOCK_HI_SLOT];
endmodule

// File: rtl/gpio_wlock_seq.sv
module gpio_wlock_seq #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic              hit_lo_i,
  input  logic              hit_hi_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              locked_o
);
  import gpio_wlock_pkg::*;

  logic locked_q, key_q;
  logic is_first, is_second, do_unlock;

  assign is_first  = (wr_data_i == DATA_W'(KEY_FIRST));
  assign is_second = (wr_data_i == DATA_W'(KEY_SECOND));
  assign do_unlock = hit_lo_i && key_q && is_second;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      key_q    <= 1'b0;
    end else if (wr_valid_i) begin
      // every write either arms the key (first key to hi slot) or disarms it
      key_q <= hit_hi_i && is_first;
      if (do_unlock)                locked_q <= 1'b0;
      else if (hit_lo_i || hit_hi_i) locked_q <= 1'b1;
    end
  end

  assign locked_o = locked_q;

  p_lock_hi_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_hi_i |=> locked_q);
  p_lock_lo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_lo_i && !(key_q && is_second)) |=> locked_q);
  p_unlock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_lo_i && key_q && is_second) |=> !locked_q);
  p_fall_needs_key_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_q) |-> $past(key_q && hit_lo_i));
  p_key_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !hit_hi_i) |=> !key_q);
  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |=> ($stable(locked_q) && $stable(key_q)));
endmodule

// File: rtl/gpio_wlock_gate.sv
module gpio_wlock_gate #(
  parameter int unsigned NSLOT = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSLOT-1:0] sel_i,
  input  logic             locked_i,
  output logic [NSLOT-1:0] permit_o
);
  import gpio_wlock_pkg::*;

  for (genvar k = 0; k < NSLOT; k++) begin : g_gate
    if (k == LOCK_LO_SLOT || k == LOCK_HI_SLOT) begin : g_lock_slot
      assign permit_o[k] = 1'b0;
    end else begin : g_data_slot
      assign permit_o[k] = sel_i[k] && !locked_i;
    end
  end

  p_no_permit_locked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_i |-> (permit_o == '0));
  p_single_permit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(permit_o));
  p_permit_has_sel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == '0) |-> (permit_o == '0));
  p_lock_slot_closed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !permit_o[LOCK_LO_SLOT] && !permit_o[LOCK_HI_SLOT]);
endmodule

// File: rtl/gpio_wlock_unit.sv
module gpio_wlock_unit #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NSLOT = 1 << (ADDR_W - 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [NSLOT-1:0]  wr_permit_o,
  output logic [DATA_W-1:0] lock_rdata_o,
  output logic              locked_o
);
  logic [NSLOT-1:0] sel;
  logic hit_lo, hit_hi, locked;

  gpio_wlock_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_valid_i (wr_valid_i),
    .wr_addr_i  (wr_addr_i),
    .sel_o      (sel),
    .hit_lo_o   (hit_lo),
    .hit_hi_o   (hit_hi)
  );

  gpio_wlock_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid_i),
    .hit_lo_i   (hit_lo),
    .hit_hi_i   (hit_hi),
    .wr_data_i  (wr_data_i),
    .locked_o   (locked)
  );

  gpio_wlock_gate #(.NSLOT(NSLOT)) u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel),
    .locked_i (locked),
    .permit_o (wr_permit_o)
  );

  assign locked_o     = locked;
  assign lock_rdata_o = {{(DATA_W-1){1'b0}}, locked};

  p_rdata_upper_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_rdata_o[DATA_W-1:1] == '0);
  p_rdata_tracks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_rdata_o[0] == locked_o);
endmodule

// File: tb/gpio_wlock_unit_tb_top.sv
module gpio_wlock_unit_tb_top;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NSLOT  = 32;
  localparam logic [31:0] K1 = 32'hC0DE_1248;
  localparam logic [31:0] K2 = 32'hC0DE_FA73;

  typedef struct {
    string       tag;
    logic [31:0] perm;
    logic        lock_after;
    logic [31:0] dout_after;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [NSLOT-1:0]  wr_permit;
  logic [DATA_W-1:0] lock_rdata;
  logic              locked;

  always #5 clk = ~clk;

  gpio_wlock_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .wr_valid_i (wr_valid),
    .wr_addr_i (wr_addr), .wr_data_i (wr_data),
    .wr_permit_o (wr_permit), .lock_rdata_o (lock_rdata), .locked_o (locked)
  );

  // shadow data-out register (slot 3) fed by the permit line
  logic [31:0] dout_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dout_q <= '0;
    else if (wr_permit[3]) dout_q <= wr_data;

  item_t q[$];
  int total = 0;
  int bad = 0;
  logic m_locked = 1'b0;
  logic m_key = 1'b0;
  logic [31:0] m_dout = '0;
  bit drv_done = 1'b0;

  task automatic cyc(input bit v, input int ofs, input logic [31:0] d, input string tag);
    item_t it;
    int slot;
    @(negedge clk);
    wr_valid = v;
    wr_addr  = ADDR_W'(ofs);
    wr_data  = d;
    slot = ofs / 4;
    it.tag  = tag;
    it.perm = '0;
    if (v && !m_locked && slot != 0 && slot != 31) it.perm[slot] = 1'b1;
    if (it.perm[3]) m_dout = d;
    if (v) begin
      if (slot == 0 && m_key && d == K2) m_locked = 1'b0;
      else if (slot == 0 || slot == 31) m_locked = 1'b1;
      m_key = (slot == 31) && (d == K1);
    end
    it.lock_after = m_locked;
    it.dout_after = m_dout;
    q.push_back(it);
  endtask

  task automatic wr(input int ofs, input logic [31:0] d, input string tag);
    cyc(1'b1, ofs, d, tag);
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 'h0C, 32'hFFFF_FFFF, tag);
  endtask

  task automatic unlock(input string tag);
    wr('h7C, K1, tag);
    wr('h00, K2, tag);
  endtask

  // monitor: permit before the edge, lock/dout after it
  initial begin
    item_t it;
    logic [31:0] perm_s;
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        perm_s = wr_permit;
        @(posedge clk);
        #1;
        total++;
        if (perm_s !== it.perm || lock_rdata !== {31'b0, it.lock_after} ||
            locked !== it.lock_after || dout_q !== it.dout_after) begin
          bad++;
          $display("FAIL %s: permit=%h lock=%h dout=%h exp permit=%h lock=%h dout=%h",
                   it.tag, perm_s, lock_rdata, dout_q, it.perm,
                   {31'b0, it.lock_after}, it.dout_after);
        end
      end
    end
  end

  initial begin
    #20_000_000;
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish, exp completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    total++;
    if (lock_rdata !== 32'h0 || wr_permit !== '0 || locked !== 1'b0) begin
      bad++;
      $display("FAIL R1: lock=%h permit=%h exp lock=0 permit=0", lock_rdata, wr_permit);
    end
    // R6 / R9 unlocked traffic
    wr('h0C, 32'h9876_5432, "R6 dout write unlocked");
    wr('h28, 32'h1111_0000, "R6 slot 10 write");
    wr('h40, 32'h0000_0001, "R6 slot 16 write");
    idle("R9 idle no permit");
    // R3 lock via primary, R5 dropped write
    wr('h00, 32'h0, "R3 lock via 0x00");
    wr('h0C, 32'hA987_6543, "R5 dout write while locked");
    wr('h10, 32'hFFFF_FFFF, "R5 other write while locked");
    unlock("R4 unlock pair");
    wr('h0C, 32'hA987_6543, "R4 dout write after unlock");
    // R3 lock via secondary
    wr('h7C, 32'h0, "R3 lock via 0x7C");
    wr('h0C, 32'h9876_5432, "R5 dropped after 0x7C lock");
    unlock("R4 unlock again");
    wr('h0C, 32'h9876_5432, "R4 write works again");
    // first key while unlocked also locks
    wr('h7C, K1, "R3 first key locks");
    wr('h00, K2, "R4 second key unlocks");
    // R7 broken sequences
    wr('h00, 32'h5, "R3 lock for R7");
    wr('h00, K2, "R7 second key alone");
    wr('h7C, K1, "R7 arm");
    wr('h0C, 32'h1234_5678, "R7 intervening write dropped");
    wr('h00, K2, "R7 key after break");
    wr('h7C, 32'hC0DE_1249, "R7 wrong first value");
    wr('h00, K2, "R7 after wrong value");
    wr('h00, K1, "R7 first key on wrong reg");
    wr('h7C, K2, "R7 second key on wrong reg");
    wr('h7C, K1, "R9 arm");
    idle("R9 idle keeps key");
    idle("R9 idle keeps key 2");
    wr('h00, K2, "R9 unlock across idle");
    wr('h7C, K1, "R7 re-arm");
    wr('h7C, K1, "R7 re-arm twice");
    wr('h00, K2, "R4 unlock after double arm");
    // R8 lock slots never permitted
    wr('h7C, 32'hDEAD_BEEF, "R8 hi slot no permit");
    unlock("R8 unlock");
    wr('h00, 32'h1, "R8 lo slot no permit");
    wr('h00, 32'h1, "R2 locked stays locked");
    unlock("R2 back to unlocked");
    for (int k = 1; k < 31; k++) wr(k * 4, 32'(k), "R6 slot sweep");
    idle("R9 final idle");
    repeat (4) @(negedge clk);
    drv_done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule